// File: doc/BRIEF.md
# Interrupt Interval Timer with Power-of-Two Prescaler

This block is a down-counting interval timer for an interrupt controller. A prescaler divides the bus clock by a power of two chosen through a four-bit divide code. Each time the prescaler wraps, the current count drops by one. Software starts the timer by writing an initial count. A vector entry holds an 8-bit vector, a mask flag and a periodic flag. In one-shot mode the count stops at zero. In periodic mode it reloads from the initial count.

Every expiry adds one to a saturating count of expirations not yet delivered. While that count is nonzero and the entry is unmasked, the block raises an interrupt request carrying the entry's vector. Each accepted request removes one expiration from the count. A global software-enable flag forces the mask on when it is cleared, and clearing it also discards any undelivered expirations. All writes go through one write port with a select field.

Top module: `irq_interval_timer`

## Requirements
- R1: The divide ratio is 2^e, where e = ({data[3], data[1], data[0]} + 1) mod 8, taken from the last write with `wr_sel`=2'b00. Data bit 2 and bits above 3 are ignored. Code 4'b1011 therefore divides by 1, code 0 divides by 2 and code 4'b0110 divides by 8.
- R2: A write with `wr_sel`=2'b01 loads value V into `cur_count` on the write edge and restarts the prescaler. With ratio r, `cur_count` then falls by exactly one at every r-th following edge.
- R3: Writing an initial count of 0 sets `cur_count` to 0 and stops the timer. No expiry follows.
- R4: In one-shot mode (entry bit 17 = 0), the edge that moves the count from 1 to 0 is an expiry. The count then stays at 0 until the next initial-count write.
- R5: In periodic mode (entry bit 17 = 1), the count goes from 1 straight back to the initial count, so an expiry occurs every V*r cycles.
- R6: Each expiry adds one to `pend_count`. The count saturates at 2^PEND_W-1 and does not wrap.
- R7: `irq_req` is high exactly when entry bit 16 (mask) is 0 and `pend_count` is nonzero, and `irq_vec` equals entry bits [7:0]. A cycle with both `irq_req` and `irq_ack` high is an acceptance and lowers `pend_count` by one. If an acceptance and an expiry fall in the same cycle, `pend_count` is unchanged.
- R8: A write with `wr_sel`=2'b10 stores only data bits [7:0], 12, 16 and 17 in `entry_word`. Every other bit reads as 0.
- R9: A write with `wr_sel`=2'b11 sets `sw_en` to data bit 8. When that bit is 0, the write sets entry bit 16 and clears `pend_count`. While `sw_en` is 0, every entry write forces bit 16 to 1.
- R10: After reset, `entry_word`=32'h0001_0000, `cur_count`=0, the initial count is 0, the divide code is 0 (divide by 2), `pend_count`=0, `sw_en`=0 and `irq_req`=0.
- R11: A divide-code write restarts the prescaler. The next decrement comes exactly r cycles after that write, whatever phase the prescaler was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 divide code, 01 initial count, 10 vector entry, 11 enable |
| wr_data | input | 32 | Write data |
| irq_ack | input | 1 | Acceptance of the current request |
| cur_count | output | CNT_W | Current count |
| entry_word | output | 32 | Stored vector entry |
| sw_en | output | 1 | Software enable flag |
| pend_count | output | PEND_W | Undelivered expirations |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector of the request |

## Verification
Two events can land on the same edge: a timer expiry, which raises the pending count, and an acceptance, which lowers it. The bench runs the timer periodically with divide-by-1 and a period of three cycles. It then pulses `irq_ack` for exactly the edge of the fourth expiry. The pending count must be the same before and after that edge, and the following expiry must raise it by one. The scoreboard also checks the count at saturation, where an expiry with no acceptance must leave it at its maximum.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

   typedef enum logic [1:0] {
      SEL_DIV    = 2'b00,
      SEL_INIT   = 2'b01,
      SEL_ENTRY  = 2'b10,
      SEL_ENABLE = 2'b11
   } wsel_e;

   localparam int          BIT_MASK     = 16;
   localparam int          BIT_PERIODIC = 17;
   localparam int          BIT_SWEN     = 8;
   localparam logic [31:0] ENTRY_KEEP   = 32'h0003_10FF;
   localparam logic [31:0] MASK_FLAG    = 32'h0001_0000;
   localparam logic [3:0]  DIV_KEEP     = 4'b1011;
   localparam int          PRE_W        = 7;

   // exponent of the divide ratio from the sparse code bits
   function automatic logic [2:0] div_exp(input logic [3:0] code);
      return {code[3], code[1:0]} + 3'd1;
   endfunction

endpackage

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
   parameter int PRE_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [2:0] expo,
   output logic       tick
);
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;

   always_comb lim = PRE_W'((8'd1 << expo) - 8'd1);

   assign tick = !restart && (pre_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pre_q <= '0;
      else if (restart || pre_q == lim)
         pre_q <= '0;
      else
         pre_q <= pre_q + PRE_W'(1);
   end
endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] cur,
   output logic             expire
);
   logic [CNT_W-1:0] init_q;
   logic [CNT_W-1:0] cur_q;

   assign expire = !load && tick && (cur_q == CNT_W'(1));
   assign cur    = cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q <= '0;
         cur_q  <= '0;
      end else if (load) begin
         init_q <= load_val;
         cur_q  <= load_val;
      end else if (tick && cur_q != '0) begin
         if (cur_q == CNT_W'(1))
            cur_q <= periodic ? init_q : '0;
         else
            cur_q <= cur_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/itmr_pend.sv
module itmr_pend #(
   parameter int PEND_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              dec,
   input  logic              clr,
   output logic [PEND_W-1:0] cnt
);
   localparam logic [PEND_W-1:0] MAXV = '1;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt <= '0;
      else if (inc && !dec && cnt != MAXV)
         cnt <= cnt + PEND_W'(1);
      else if (dec && !inc && cnt != '0)
         cnt <= cnt - PEND_W'(1);
   end
endmodule

// File: rtl/irq_interval_timer.sv
module irq_interval_timer
   import itmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int PEND_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              irq_ack,
   output logic [CNT_W-1:0]  cur_count,
   output logic [31:0]       entry_word,
   output logic              sw_en,
   output logic [PEND_W-1:0] pend_count,
   output logic              irq_req,
   output logic [7:0]        irq_vec
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("irq_interval_timer: CNT_W must lie in 2..32");
   end
   if (PEND_W < 1 || PEND_W > 16) begin : g_bad_pend
      $error("irq_interval_timer: PEND_W must lie in 1..16");
   end

   wsel_e            sel;
   logic             wr_div, wr_init, wr_ent, wr_enb, clear_all;
   logic [3:0]       div_code_q;
   logic [31:0]      entry_q;
   logic             swen_q;
   logic             tick, tmr_expire, accept;
   logic [CNT_W-1:0] load_val;

   assign sel       = wsel_e'(wr_sel);
   assign wr_div    = wr_en && sel == SEL_DIV;
   assign wr_init   = wr_en && sel == SEL_INIT;
   assign wr_ent    = wr_en && sel == SEL_ENTRY;
   assign wr_enb    = wr_en && sel == SEL_ENABLE;
   assign clear_all = wr_enb && !wr_data[BIT_SWEN];

   if (CNT_W == 32) begin : g_full
      assign load_val = wr_data;
   end else begin : g_part
      assign load_val = wr_data[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_code_q <= '0;
         entry_q    <= MASK_FLAG;
         swen_q     <= 1'b0;
      end else begin
         if (wr_div)
            div_code_q <= wr_data[3:0] & DIV_KEEP;
         if (wr_enb)
            swen_q <= wr_data[BIT_SWEN];
         if (wr_ent)
            entry_q <= (wr_data & ENTRY_KEEP) | (swen_q ? 32'h0 : MASK_FLAG);
         else if (clear_all)
            entry_q <= entry_q | MASK_FLAG;
      end
   end

   itmr_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_div || wr_init),
      .expo    (div_exp(div_code_q)),
      .tick    (tick)
   );

   itmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_init),
      .load_val (load_val),
      .tick     (tick),
      .periodic (entry_q[BIT_PERIODIC]),
      .cur      (cur_count),
      .expire   (tmr_expire)
   );

   itmr_pend #(.PEND_W(PEND_W)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (tmr_expire),
      .dec   (accept),
      .clr   (clear_all),
      .cnt   (pend_count)
   );

   assign irq_req    = !entry_q[BIT_MASK] && pend_count != '0;
   assign irq_vec    = entry_q[7:0];
   assign accept     = irq_req && irq_ack;
   assign entry_word = entry_q;
   assign sw_en      = swen_q;
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
   parameter int CNT_W  = 32,
   parameter int PEND_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [31:0]       wr_data,
   input logic              irq_ack,
   input logic [CNT_W-1:0]  cur_count,
   input logic [31:0]       entry_word,
   input logic [PEND_W-1:0] pend_count,
   input logic              irq_req,
   input logic              expire
);
   localparam logic [PEND_W-1:0] MAXV = '1;

   logic acc, clr, ld;
   assign acc = irq_req && irq_ack;
   assign clr = wr_en && wr_sel == 2'b11 && !wr_data[8];
   assign ld  = wr_en && wr_sel == 2'b01;

   p_pend_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !acc && !clr && pend_count != MAXV) |=> pend_count == $past(pend_count) + PEND_W'(1));

   p_pend_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_count == MAXV && !acc && !clr) |=> pend_count == MAXV);

   p_accept_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !expire && !clr) |=> pend_count == $past(pend_count) - PEND_W'(1));

   p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && expire && !clr) |=> $stable(pend_count));

   p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_count == '0 && !ld) |=> cur_count == '0);

   p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (entry_word[16] && pend_count == '0 && !irq_req));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_count > CNT_W'(1) && !ld) |=>
         (cur_count == $past(cur_count) || cur_count == $past(cur_count) - CNT_W'(1)));
endmodule

bind irq_interval_timer itmr_checker #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .wr_data    (wr_data),
   .irq_ack    (irq_ack),
   .cur_count  (cur_count),
   .entry_word (entry_word),
   .pend_count (pend_count),
   .irq_req    (irq_req),
   .expire     (tmr_expire)
);

// File: tb/sim_irq_interval_timer.sv
`timescale 1ns/1ps
module sim_irq_interval_timer;
   localparam int CNT_W  = 32;
   localparam int PEND_W = 4;
   localparam int K_CUR = 0, K_PEND = 1, K_REQ = 2, K_VEC = 3, K_ENT = 4, K_SWEN = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_sel = 2'b00;
   logic [31:0]       wr_data = 32'h0;
   logic              irq_ack = 1'b0;
   logic [CNT_W-1:0]  cur_count;
   logic [31:0]       entry_word;
   logic              sw_en;
   logic [PEND_W-1:0] pend_count;
   logic              irq_req;
   logic [7:0]        irq_vec;

   irq_interval_timer #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .irq_ack(irq_ack), .cur_count(cur_count), .entry_word(entry_word), .sw_en(sw_en),
      .pend_count(pend_count), .irq_req(irq_req), .irq_vec(irq_vec));

   always #2.5 clk = ~clk;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int          at;
      int          kind;
      logic [31:0] val;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   function automatic logic [31:0] probe(input int kind);
      case (kind)
         K_CUR:   return 32'(cur_count);
         K_PEND:  return 32'(pend_count);
         K_REQ:   return 32'(irq_req);
         K_VEC:   return 32'(irq_vec);
         K_ENT:   return entry_word;
         default: return 32'(sw_en);
      endcase
   endfunction

   // monitor: compare scoreboard items due in this cycle
   always @(negedge clk) begin
      for (int i = sbq.size() - 1; i >= 0; i--) begin
         if (sbq[i].at == cyc) begin
            logic [31:0] act;
            act = probe(sbq[i].kind);
            checks++;
            if (act !== sbq[i].val) begin
               errors++;
               $display("FAIL %s kind %0d cycle %0d: actual %h expected %h",
                        sbq[i].tag, sbq[i].kind, cyc, act, sbq[i].val);
            end
            sbq.delete(i);
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual cycle %0d expected end before 20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic expect_at(input int at, input int kind, input logic [31:0] val, input string tag);
      exp_t it;
      it.at = at; it.kind = kind; it.val = val; it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d, output int e);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      e = cyc;
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic ack_at(input int edge_no);
      wait_to(edge_no - 1);
      irq_ack = 1'b1;
      @(posedge clk); #1;
      irq_ack = 1'b0;
   endtask

   initial begin
      int e, w, a;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10 reset state
      expect_at(cyc + 1, K_CUR, 0, "R10");
      expect_at(cyc + 1, K_PEND, 0, "R10");
      expect_at(cyc + 1, K_REQ, 0, "R10");
      expect_at(cyc + 1, K_ENT, 32'h0001_0000, "R10");
      expect_at(cyc + 1, K_SWEN, 0, "R10");
      wait_to(cyc + 2);

      wr(2'b11, 32'h0000_0100, e);
      expect_at(e, K_SWEN, 1, "R9");
      wr(2'b10, 32'hFFFC_1055, e);
      expect_at(e, K_ENT, 32'h0000_1055, "R8");

      // one-shot with reset divide code (divide by 2): R10 R2 R4
      wr(2'b01, 32'd3, e);
      expect_at(e,      K_CUR, 3, "R2");
      expect_at(e + 1,  K_CUR, 3, "R10");
      expect_at(e + 2,  K_CUR, 2, "R2");
      expect_at(e + 4,  K_CUR, 1, "R2");
      expect_at(e + 5,  K_PEND, 0, "R6");
      expect_at(e + 6,  K_CUR, 0, "R4");
      expect_at(e + 6,  K_PEND, 1, "R6");
      expect_at(e + 6,  K_REQ, 1, "R7");
      expect_at(e + 6,  K_VEC, 32'h55, "R7");
      expect_at(e + 12, K_CUR, 0, "R4");
      expect_at(e + 12, K_PEND, 1, "R4");
      wait_to(e + 13);
      a = cyc + 2;
      expect_at(a, K_PEND, 0, "R7");
      expect_at(a, K_REQ, 0, "R7");
      ack_at(a);

      // divide by 8 with ignored bit 2: R1
      wr(2'b00, 32'h0000_0006, e);
      wr(2'b01, 32'd2, e);
      expect_at(e + 7,  K_CUR, 2, "R1");
      expect_at(e + 8,  K_CUR, 1, "R1");
      expect_at(e + 16, K_CUR, 0, "R1");
      expect_at(e + 16, K_PEND, 1, "R1");
      wait_to(e + 17);
      a = cyc + 2;
      expect_at(a, K_PEND, 0, "R7");
      ack_at(a);

      // divide by 1: R1
      wr(2'b00, 32'h0000_000B, e);
      wr(2'b01, 32'd4, e);
      expect_at(e + 1, K_CUR, 3, "R1");
      expect_at(e + 3, K_CUR, 1, "R1");
      expect_at(e + 4, K_CUR, 0, "R1");
      expect_at(e + 4, K_PEND, 1, "R1");
      wait_to(e + 5);
      a = cyc + 2;
      expect_at(a, K_PEND, 0, "R7");
      ack_at(a);

      // periodic, same-cycle expiry and acceptance, saturation: R5 R6 R7
      wr(2'b10, 32'h0002_0077, e);
      expect_at(e, K_ENT, 32'h0002_0077, "R8");
      wr(2'b01, 32'd3, e);
      expect_at(e + 1,  K_CUR, 2, "R5");
      expect_at(e + 2,  K_CUR, 1, "R5");
      expect_at(e + 3,  K_CUR, 3, "R5");
      expect_at(e + 3,  K_PEND, 1, "R5");
      expect_at(e + 4,  K_VEC, 32'h77, "R7");
      expect_at(e + 6,  K_PEND, 2, "R5");
      expect_at(e + 9,  K_PEND, 3, "R6");
      expect_at(e + 11, K_PEND, 3, "R7");
      expect_at(e + 12, K_PEND, 3, "R7");
      expect_at(e + 13, K_PEND, 3, "R7");
      expect_at(e + 15, K_PEND, 4, "R6");
      expect_at(e + 45, K_PEND, 14, "R6");
      expect_at(e + 51, K_PEND, 15, "R6");
      expect_at(e + 57, K_PEND, 15, "R6");
      ack_at(e + 12);
      wait_to(e + 60);

      // stop with zero: R3
      wr(2'b01, 32'd0, w);
      expect_at(w,      K_CUR, 0, "R3");
      expect_at(w + 10, K_CUR, 0, "R3");
      expect_at(w + 10, K_PEND, 15, "R3");
      wait_to(w + 11);

      // masking: R7
      wr(2'b10, 32'h0001_0077, w);
      expect_at(w, K_REQ, 0, "R7");
      expect_at(w, K_ENT, 32'h0001_0077, "R8");
      wr(2'b10, 32'h0000_0077, w);
      expect_at(w, K_REQ, 1, "R7");
      a = cyc + 2;
      expect_at(a, K_PEND, 14, "R7");
      ack_at(a);

      // software disable: R9
      wr(2'b11, 32'h0000_0000, w);
      expect_at(w, K_ENT, 32'h0001_0077, "R9");
      expect_at(w, K_PEND, 0, "R9");
      expect_at(w, K_REQ, 0, "R9");
      expect_at(w, K_SWEN, 0, "R9");
      wr(2'b10, 32'h0000_0033, w);
      expect_at(w, K_ENT, 32'h0001_0033, "R9");

      // divide write restarts prescaler: R11
      wr(2'b00, 32'h0000_0001, e);
      wr(2'b01, 32'd5, e);
      expect_at(e + 4, K_CUR, 4, "R11");
      wait_to(e + 4);
      wr(2'b00, 32'h0000_0001, w);
      expect_at(w,     K_CUR, 4, "R11");
      expect_at(w + 3, K_CUR, 4, "R11");
      expect_at(w + 4, K_CUR, 3, "R11");
      wait_to(w + 6);

      foreach (sbq[i]) begin
         errors++;
         $display("FAIL %s kind %0d: actual unchecked expected %h at cycle %0d",
                  sbq[i].tag, sbq[i].kind, sbq[i].val, sbq[i].at);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule